// File: doc/BRIEF.md
# Two-Lane Time-Shared Crossbar Switch

This block is the switch-traversal stage of a five-port mesh router that carries two virtual lanes. Rather than giving each lane its own switch, one non-blocking crossbar is shared by both lanes. Each router clock period is split into two slots: the first slot switches lane 0 and the second slot switches lane 1. The design is clocked by a double-rate clock (`clk`, two edges of `clk` per router cycle). An internal slot register alternates every `clk` cycle and starts with the lane 0 slot after reset.

For each input port and each lane, the requester provides a flit, a valid bit and the index of the output port it was granted. These inputs are held for a whole router period. Arbitration upstream guarantees that no two valid inputs of the same lane target the same output. The result of lane 0 is parked in a holding register at the end of its slot. At the end of the lane 1 slot, both lanes' results are loaded into the output registers together. As a result, every output port presents a lane 0 flit and a lane 1 flit aligned to the same router-cycle boundary.

Top module: `lane_xbar_ddr`

## Requirements
- R1: While `rst_n` is low, every output valid bit and data word is zero and `lane_slot` is 0.
- R2: After reset, `lane_slot` is 0 (lane 0 slot) in the first `clk` cycle and then alternates every `clk` cycle.
- R3: A valid flit on input p, lane L, with select value o (0 to PORTS-1) appears on output o, lane L, with identical data. It appears at the edge that ends the next lane 1 slot, which is two `clk` edges after it is presented at the start of a lane 0 slot.
- R4: Any set of valid inputs that target distinct outputs within a lane is switched completely in one router period, including full permutations of all five ports. Two valid inputs of one lane that select the same output are a usage error and are flagged.
- R5: An output/lane pair that no valid input selects shows valid 0 and data all zero.
- R6: The two lanes are routed independently. The same input may go to different outputs on the two lanes, and lane 0 data never appears on a lane 1 output or the reverse.
- R7: Outputs change only at the edge that ends a lane 1 slot. During the lane 1 slot they still show the previous period's results.
- R8: Lane 0 inputs are taken only at the end of the lane 0 slot. A change to lane 0 inputs during the lane 1 slot has no effect on that period's outputs, while a change to lane 1 inputs in the same slot does take effect.
- R9: A valid flit whose select value is PORTS or larger reaches no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two cycles per router period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | PORTS*2*W | Flit per input and lane, entry index port*2+lane |
| in_vld | input | PORTS*2 | Valid per input and lane, same indexing |
| in_sel | input | PORTS*2*SW | Granted output index per input and lane, SW = clog2(PORTS) bits each |
| out_data | output | PORTS*2*W | Switched flit per output and lane, entry index port*2+lane |
| out_vld | output | PORTS*2 | Valid per output and lane |
| lane_slot | output | 1 | Lane currently switched: 0 = lane 0 slot, 1 = lane 1 slot |

## Verification
A single routed flit with all other inputs idle separates correct routing from wrong destination or lane mixing. The idle outputs in that test also prove zero fill. Full rotations on lane 0 combined with a reversal on lane 1 show that the fabric is non-blocking and that the two lanes are selected independently. Out-of-range selects and all-invalid inputs with noisy data and selects separate valid-gated routing from routing that merely decodes the select value. Sampling in mid-period, and changing inputs inside the lane 1 slot, show whether both lanes are re-aligned to one boundary and whether each lane is latched in its own slot.

// File: rtl/xbar_ddr_pkg.sv
`timescale 1ns/1ps
package xbar_ddr_pkg;
   localparam int unsigned NUM_LANES = 2;
   localparam int MUX_ANDOR = 0;
   localparam int MUX_PRIO  = 1;

   typedef enum logic {
      SLOT_L0 = 1'b0,
      SLOT_L1 = 1'b1
   } slot_e;

   function automatic int unsigned ent(input int unsigned port, input int unsigned lane);
      return port * NUM_LANES + lane;
   endfunction
endpackage

// File: rtl/xbar_slot_seq.sv
`timescale 1ns/1ps
module xbar_slot_seq
   import xbar_ddr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= SLOT_L0;
      else        slot <= (slot == SLOT_L0) ? SLOT_L1 : SLOT_L0;
   end
endmodule

// File: rtl/xbar_fabric.sv
`timescale 1ns/1ps
module xbar_fabric
   import xbar_ddr_pkg::*;
#(
   parameter int PORTS     = 5,
   parameter int W         = 36,
   parameter int SW        = 3,
   parameter int MUX_STYLE = MUX_ANDOR
) (
   input  logic [PORTS*W-1:0]  src_data,
   input  logic [PORTS-1:0]    src_vld,
   input  logic [PORTS*SW-1:0] src_sel,
   output logic [PORTS*W-1:0]  dst_data,
   output logic [PORTS-1:0]    dst_vld
);
   for (genvar o = 0; o < PORTS; o++) begin : g_out
      logic [PORTS-1:0] hit;
      logic [W-1:0]     pick;

      for (genvar i = 0; i < PORTS; i++) begin : g_hit
         assign hit[i] = src_vld[i] && (src_sel[i*SW +: SW] == SW'(o));
      end

      if (MUX_STYLE == MUX_ANDOR) begin : g_andor
         always_comb begin
            pick = '0;
            for (int i = 0; i < PORTS; i++)
               pick = pick | ({W{hit[i]}} & src_data[i*W +: W]);
         end
      end else begin : g_prio
         always_comb begin
            pick = '0;
            for (int i = PORTS - 1; i >= 0; i--)
               if (hit[i]) pick = src_data[i*W +: W];
         end
      end

      assign dst_vld[o]         = |hit;
      assign dst_data[o*W +: W] = pick;
   end
endmodule

// File: rtl/xbar_realign.sv
`timescale 1ns/1ps
module xbar_realign
   import xbar_ddr_pkg::*;
#(
   parameter int PORTS = 5,
   parameter int W     = 36
) (
   input  logic               clk,
   input  logic               rst_n,
   input  slot_e              slot,
   input  logic [PORTS*W-1:0] res_data,
   input  logic [PORTS-1:0]   res_vld,
   output logic [PORTS*W-1:0] l0_data,
   output logic [PORTS-1:0]   l0_vld,
   output logic [PORTS*W-1:0] l1_data,
   output logic [PORTS-1:0]   l1_vld
);
   logic [PORTS*W-1:0] park_data;
   logic [PORTS-1:0]   park_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         park_data <= '0;
         park_vld  <= '0;
         l0_data   <= '0;
         l0_vld    <= '0;
         l1_data   <= '0;
         l1_vld    <= '0;
      end else if (slot == SLOT_L0) begin
         park_data <= res_data;
         park_vld  <= res_vld;
      end else begin
         l0_data <= park_data;
         l0_vld  <= park_vld;
         l1_data <= res_data;
         l1_vld  <= res_vld;
      end
   end
endmodule

// File: rtl/lane_xbar_ddr.sv
`timescale 1ns/1ps
module lane_xbar_ddr
   import xbar_ddr_pkg::*;
#(
   parameter int PORTS     = 5,
   parameter int W         = 36,
   parameter int MUX_STYLE = MUX_ANDOR,
   localparam int SW       = (PORTS > 1) ? $clog2(PORTS) : 1,
   localparam int LN       = NUM_LANES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORTS*LN*W-1:0]  in_data,
   input  logic [PORTS*LN-1:0]    in_vld,
   input  logic [PORTS*LN*SW-1:0] in_sel,
   output logic [PORTS*LN*W-1:0]  out_data,
   output logic [PORTS*LN-1:0]    out_vld,
   output logic                  lane_slot
);
   if (PORTS < 2) begin : g_bad_ports
      $error("lane_xbar_ddr: PORTS must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("lane_xbar_ddr: W must be positive");
   end
   if (MUX_STYLE != MUX_ANDOR && MUX_STYLE != MUX_PRIO) begin : g_bad_style
      $error("lane_xbar_ddr: unknown MUX_STYLE");
   end

   slot_e slot;

   logic [PORTS*W-1:0]  cur_data;
   logic [PORTS-1:0]    cur_vld;
   logic [PORTS*SW-1:0] cur_sel;
   logic [PORTS*W-1:0]  sw_data;
   logic [PORTS-1:0]    sw_vld;
   logic [PORTS*W-1:0]  l0_data, l1_data;
   logic [PORTS-1:0]    l0_vld, l1_vld;

   xbar_slot_seq i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   for (genvar p = 0; p < PORTS; p++) begin : g_in
      localparam int unsigned E0 = ent(p, 0);
      localparam int unsigned E1 = ent(p, 1);
      always_comb begin
         if (slot == SLOT_L1) begin
            cur_data[p*W +: W]   = in_data[E1*W +: W];
            cur_vld[p]           = in_vld[E1];
            cur_sel[p*SW +: SW]  = in_sel[E1*SW +: SW];
         end else begin
            cur_data[p*W +: W]   = in_data[E0*W +: W];
            cur_vld[p]           = in_vld[E0];
            cur_sel[p*SW +: SW]  = in_sel[E0*SW +: SW];
         end
      end
   end

   xbar_fabric #(
      .PORTS     (PORTS),
      .W         (W),
      .SW        (SW),
      .MUX_STYLE (MUX_STYLE)
   ) i_fabric (
      .src_data (cur_data),
      .src_vld  (cur_vld),
      .src_sel  (cur_sel),
      .dst_data (sw_data),
      .dst_vld  (sw_vld)
   );

   xbar_realign #(
      .PORTS (PORTS),
      .W     (W)
   ) i_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .res_data (sw_data),
      .res_vld  (sw_vld),
      .l0_data  (l0_data),
      .l0_vld   (l0_vld),
      .l1_data  (l1_data),
      .l1_vld   (l1_vld)
   );

   for (genvar o = 0; o < PORTS; o++) begin : g_outp
      localparam int unsigned E0 = ent(o, 0);
      localparam int unsigned E1 = ent(o, 1);
      assign out_data[E0*W +: W] = l0_data[o*W +: W];
      assign out_data[E1*W +: W] = l1_data[o*W +: W];
      assign out_vld[E0]         = l0_vld[o];
      assign out_vld[E1]         = l1_vld[o];
   end

   assign lane_slot = (slot == SLOT_L1);
endmodule

// File: rtl/xbar_ddr_chk.sv
`timescale 1ns/1ps
module xbar_ddr_chk #(
   parameter int PORTS = 5,
   parameter int W     = 36,
   localparam int SW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [PORTS*2-1:0]    in_vld,
   input logic [PORTS*2*SW-1:0] in_sel,
   input logic [PORTS*2*W-1:0]  out_data,
   input logic [PORTS*2-1:0]    out_vld,
   input logic                  lane_slot
);
   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (out_vld == '0 && out_data == '0 && lane_slot == 1'b0)
            else $error("outputs not quiet in reset"); // R1
      end
   end

   AST_SLOT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> lane_slot != $past(lane_slot))
      else $error("slot failed to alternate"); // R2

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lane_slot |-> ($stable(out_vld) && $stable(out_data)))
      else $error("outputs moved outside the period boundary"); // R7

   for (genvar l = 0; l < 2; l++) begin : g_lane
      for (genvar o = 0; o < PORTS; o++) begin : g_dst
         logic [PORTS-1:0] hit;
         for (genvar i = 0; i < PORTS; i++) begin : g_src
            assign hit[i] = in_vld[i*2+l] && (in_sel[(i*2+l)*SW +: SW] == SW'(o));
         end
         AST_SEL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= 1)
            else $error("two inputs of one lane select the same output"); // R4
      end
   end

   for (genvar k = 0; k < PORTS*2; k++) begin : g_idle
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !out_vld[k] |-> out_data[k*W +: W] == '0)
         else $error("idle output carries data"); // R5
   end
endmodule

bind lane_xbar_ddr xbar_ddr_chk #(
   .PORTS (PORTS),
   .W     (W)
) i_xbar_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vld    (in_vld),
   .in_sel    (in_sel),
   .out_data  (out_data),
   .out_vld   (out_vld),
   .lane_slot (lane_slot)
);

// File: tb/test_lane_xbar_ddr.sv
`timescale 1ns/1ps
module test_lane_xbar_ddr;
   localparam int P  = 5;
   localparam int W  = 36;
   localparam int SW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [P*2*W-1:0]  in_data = '0;
   logic [P*2-1:0]    in_vld = '0;
   logic [P*2*SW-1:0] in_sel = '0;
   logic [P*2*W-1:0]  out_data;
   logic [P*2-1:0]    out_vld;
   logic              lane_slot;

   int n_chk = 0;
   int n_fail = 0;

   logic [W-1:0]  bd [P][2];
   logic          bv [P][2];
   logic [SW-1:0] bs [P][2];
   logic [W-1:0]  ed [P][2];
   logic          ev [P][2];

   always #2 clk = ~clk;

   lane_xbar_ddr i_lane_xbar_ddr (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_vld    (in_vld),
      .in_sel    (in_sel),
      .out_data  (out_data),
      .out_vld   (out_vld),
      .lane_slot (lane_slot)
   );

   function automatic logic [W-1:0] mk(input int seed, input int p, input int l);
      return {4'(seed) ^ 4'h9, 32'(seed * 4096 + p * 16 + l + 1)};
   endfunction

   task automatic clear_in();
      for (int p = 0; p < P; p++)
         for (int l = 0; l < 2; l++) begin
            bd[p][l] = '0; bv[p][l] = 1'b0; bs[p][l] = '0;
         end
   endtask

   task automatic drive();
      for (int p = 0; p < P; p++)
         for (int l = 0; l < 2; l++) begin
            in_data[(p*2+l)*W +: W]   = bd[p][l];
            in_vld[p*2+l]             = bv[p][l];
            in_sel[(p*2+l)*SW +: SW]  = bs[p][l];
         end
   endtask

   task automatic calc_exp(input int l);
      for (int o = 0; o < P; o++) begin
         ev[o][l] = 1'b0;
         ed[o][l] = '0;
         for (int p = 0; p < P; p++)
            if (bv[p][l] && int'(bs[p][l]) == o) begin
               ev[o][l] = 1'b1;
               ed[o][l] = bd[p][l];
            end
      end
   endtask

   task automatic check_all(input string tag);
      for (int o = 0; o < P; o++)
         for (int l = 0; l < 2; l++) begin
            n_chk++;
            if (out_vld[o*2+l] !== ev[o][l] || out_data[(o*2+l)*W +: W] !== ed[o][l]) begin
               n_fail++;
               $display("FAIL %s out %0d lane %0d: got vld=%0b data=%h, expected vld=%0b data=%h",
                        tag, o, l, out_vld[o*2+l], out_data[(o*2+l)*W +: W], ev[o][l], ed[o][l]);
            end
         end
   endtask

   task automatic check_slot(input string tag, input logic expv);
      n_chk++;
      if (lane_slot !== expv) begin
         n_fail++;
         $display("FAIL %s slot: got %0b, expected %0b", tag, lane_slot, expv);
      end
   endtask

   task automatic sync0();
      @(negedge clk);
      while (lane_slot !== 1'b0) @(negedge clk);
   endtask

   task automatic run_period(input string tag);
      sync0();
      drive();
      calc_exp(0);
      calc_exp(1);
      @(negedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      clear_in();
      for (int o = 0; o < P; o++)
         for (int l = 0; l < 2; l++) begin ev[o][l] = 1'b0; ed[o][l] = '0; end
      check_all("R1");
      check_slot("R1", 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_slot();
      check_slot("R2", 1'b0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check_slot("R2", (k % 2 == 0) ? 1'b1 : 1'b0);
      end
   endtask

   task automatic t_single();
      clear_in();
      bd[2][1] = mk(1, 2, 1); bv[2][1] = 1'b1; bs[2][1] = 3'd4;
      bd[0][0] = mk(1, 0, 0); bs[0][0] = 3'd4;
      run_period("R3");
      clear_in();
      bd[4][0] = mk(2, 4, 0); bv[4][0] = 1'b1; bs[4][0] = 3'd0;
      run_period("R3");
   endtask

   task automatic t_perm();
      clear_in();
      for (int p = 0; p < P; p++) begin
         bd[p][0] = mk(3, p, 0); bv[p][0] = 1'b1; bs[p][0] = SW'((p + 1) % P);
         bd[p][1] = mk(4, p, 1); bv[p][1] = 1'b1; bs[p][1] = SW'(P - 1 - p);
      end
      run_period("R4");
      for (int p = 0; p < P; p++) begin
         bs[p][0] = SW'((p + 3) % P);
         bs[p][1] = SW'((p + 3) % P);
         bd[p][0] = mk(5, p, 0);
         bd[p][1] = mk(6, p, 1);
      end
      run_period("R6");
   endtask

   task automatic t_idle();
      clear_in();
      for (int p = 0; p < P; p++)
         for (int l = 0; l < 2; l++) begin
            bd[p][l] = mk(7, p, l); bs[p][l] = SW'(p);
         end
      run_period("R5");
   endtask

   task automatic t_range();
      clear_in();
      bd[0][0] = mk(8, 0, 0); bv[0][0] = 1'b1; bs[0][0] = 3'd5;
      bd[1][1] = mk(8, 1, 1); bv[1][1] = 1'b1; bs[1][1] = 3'd7;
      bd[3][0] = mk(8, 3, 0); bv[3][0] = 1'b1; bs[3][0] = 3'd6;
      bd[2][1] = mk(8, 2, 1); bv[2][1] = 1'b1; bs[2][1] = 3'd1;
      run_period("R9");
   endtask

   task automatic t_hold();
      clear_in();
      for (int p = 0; p < P; p++) begin
         bd[p][0] = mk(9, p, 0); bv[p][0] = 1'b1; bs[p][0] = SW'(p);
      end
      run_period("R7");
      sync0();
      clear_in();
      bd[1][1] = mk(10, 1, 1); bv[1][1] = 1'b1; bs[1][1] = 3'd3;
      drive();
      @(negedge clk);
      check_all("R7");
      calc_exp(0);
      calc_exp(1);
      @(negedge clk);
      check_all("R7");
   endtask

   task automatic t_late();
      clear_in();
      for (int p = 0; p < P; p++) begin
         bd[p][0] = mk(11, p, 0); bv[p][0] = 1'b1; bs[p][0] = SW'((p + 2) % P);
         bd[p][1] = mk(12, p, 1); bv[p][1] = 1'b1; bs[p][1] = SW'((p + 4) % P);
      end
      sync0();
      drive();
      calc_exp(0);
      @(negedge clk);
      for (int p = 0; p < P; p++) begin
         bd[p][0] = mk(13, p, 0);
         bd[p][1] = mk(14, p, 1);
      end
      drive();
      calc_exp(1);
      @(negedge clk);
      check_all("R8");
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_slot();
      t_single();
      t_perm();
      t_idle();
      t_range();
      t_hold();
      t_late();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule